// File: doc/BRIEF.md
# Weighted Two-Class Code-Block Scheduler

This block shares one outbound host-interface path between two traffic classes: uplink (decode) and downlink (encode). Each class offers its code blocks as streams of beats on a valid/ready handshake, with a last flag on the final beat. The scheduler forwards one class at a time. Once it has chosen a class, it keeps that choice until the block's last beat is accepted, so beats from two blocks never mix on the output.

Sharing is counted in whole code blocks, and the length of a block does not matter. Each class has an 8-bit weight. A round gives a class an allowance of three blocks for every unit of weight. For example, a wanted rate ratio of 12:1 is programmed as weights 12 and 1, which gives 36:3 blocks per round. The allowance only matters when both classes are waiting. A class that is waiting alone is served at once, so the output never idles while there is work. The weights are plain configuration inputs that the surrounding logic drives.

Top module: `cb_sched_top`

## Requirements
- R1: After reset no block is in progress and no round allowance is held. With both class inputs idle, out_valid, ul_ready and dl_ready are all low.
- R2: When no block is in progress and exactly one class presents valid, that class is forwarded in the same cycle, whatever its remaining allowance.
- R3: Once the first beat of a block has been accepted, only that class is forwarded, and the other class's ready stays low, until a beat with last set is accepted from it.
- R4: A round gives each class an allowance of weight×3 code blocks. Starting a block uses one unit of allowance, whatever the block's length. With weights 12 and 1 and both classes always pending, the first 39 blocks are 36 uplink and 3 downlink.
- R5: When both classes wait at a block boundary and both have allowance left, or neither has, the class that was not served most recently wins. After reset, uplink counts as the more deserving class.
- R6: When both classes wait at a block boundary and only one of them has allowance left, that class wins.
- R7: Both allowances reload to weight×3 when both are used up, and whenever no block is in progress and neither class is valid.
- R8: A class with weight 0 is forwarded only while the other class is not valid. If both weights are 0, the two classes alternate block by block.
- R9: out_data and out_last equal the data and last of the forwarded class. out_class is 0 for uplink and 1 for downlink.
- R10: A class's ready equals out_ready when that class is the one being forwarded, and is low otherwise. The two readies are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ul_weight | input | 8 | Uplink share weight |
| dl_weight | input | 8 | Downlink share weight |
| ul_valid | input | 1 | Uplink beat valid |
| ul_last | input | 1 | Uplink final beat of block |
| ul_data | input | DW (16) | Uplink beat data |
| ul_ready | output | 1 | Uplink beat accepted when high with ul_valid |
| dl_valid | input | 1 | Downlink beat valid |
| dl_last | input | 1 | Downlink final beat of block |
| dl_data | input | DW (16) | Downlink beat data |
| dl_ready | output | 1 | Downlink beat accepted when high with dl_valid |
| out_valid | output | 1 | Forwarded beat valid |
| out_last | output | 1 | Forwarded final beat |
| out_data | output | DW (16) | Forwarded beat data |
| out_class | output | 1 | Class of forwarded beat, 0 = uplink, 1 = downlink |
| out_ready | input | 1 | Downstream accepts the beat |

## Verification
The assertions check on every cycle that:
- the readies are exclusive;
- the forwarded class stays fixed and the other class is held off while a block is in progress;
- a lone waiting class is forwarded at once;
- a class with allowance beats one without;
- each allowance counter steps down by exactly one per started block, or reloads when idle.

Several behaviours only show over a sequence of blocks, so only the bench's scenarios can show them:
- the 36:3 split over a whole round;
- the reload when both allowances run out together;
- the starvation of a zero-weight class under contention;
- plain alternation when both weights are zero.

The bench also compares the full output against its own round model under random lengths, random gaps and random back-pressure.

// File: rtl/cb_sched_pkg.sv
package cb_sched_pkg;
  typedef enum logic {CLS_UL = 1'b0, CLS_DL = 1'b1} cls_e;

  // Winner at a block boundary when both classes wait.
  function automatic cls_e contend_pick(input logic ul_has, input logic dl_has,
                                        input cls_e last_served);
    if (ul_has == dl_has) return (last_served == CLS_UL) ? CLS_DL : CLS_UL;
    return dl_has ? CLS_DL : CLS_UL;
  endfunction
endpackage

// File: rtl/cb_credit.sv
module cb_credit #(
  parameter int WW   = 8,
  parameter int UNIT = 3,
  localparam int CW  = $clog2(((1 << WW) - 1) * UNIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] weight,
  input  logic          round_reload,
  input  logic          commit,
  input  logic          take,
  input  logic          idle_reload,
  output logic [CW-1:0] eff,
  output logic          cnt_zero
);
  function automatic logic [CW-1:0] credit_of(input logic [WW-1:0] w);
    return CW'(w) * CW'(UNIT);
  endfunction

  function automatic logic [CW-1:0] spend(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  logic [CW-1:0] cnt_q, cnt_d, full;

  assign full     = credit_of(weight);
  assign eff      = round_reload ? full : cnt_q;
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (take)             cnt_d = spend(eff);
    else if (commit)      cnt_d = eff;
    else if (idle_reload) cnt_d = full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: a started block costs exactly one unit
  p_take_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && eff != '0) |=> (cnt_q == $past(eff) - 1'b1));
  // R7: idle boundary refills the allowance
  p_idle_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_reload && !commit) |=> (cnt_q == $past(full)));
endmodule

// File: rtl/cb_lock.sv
module cb_lock
  import cb_sched_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic fire_last,
  input  cls_e pick_sel,
  output logic locked,
  output cls_e owner,
  output cls_e last_served,
  output logic start
);
  logic lock_q;
  cls_e own_q, last_q;

  assign locked      = lock_q;
  assign owner       = own_q;
  assign last_served = last_q;
  assign start       = fire && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      own_q  <= CLS_UL;
      last_q <= CLS_DL;
    end else if (start) begin
      own_q  <= pick_sel;
      last_q <= pick_sel;
      lock_q <= !fire_last;
    end else if (fire && fire_last) begin
      lock_q <= 1'b0;
    end
  end

  // R3: owner holds until its last beat is taken
  p_hold_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !(fire && fire_last)) |=> (lock_q && $stable(own_q)));
endmodule

// File: rtl/cb_sched_top.sv
module cb_sched_top
  import cb_sched_pkg::*;
#(
  parameter int DW   = 16,
  parameter int WW   = 8,
  parameter int UNIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] ul_weight,
  input  logic [WW-1:0] dl_weight,
  input  logic          ul_valid,
  input  logic          ul_last,
  input  logic [DW-1:0] ul_data,
  output logic          ul_ready,
  input  logic          dl_valid,
  input  logic          dl_last,
  input  logic [DW-1:0] dl_data,
  output logic          dl_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic [DW-1:0] out_data,
  output logic          out_class,
  input  logic          out_ready
);
  localparam int CW = $clog2(((1 << WW) - 1) * UNIT + 1);

  logic          locked, start, fire, fire_last, idle, both_zero, grant_ok;
  cls_e          owner, last_served, pick_sel, cur_sel;
  logic [CW-1:0] ul_eff, dl_eff;
  logic          ul_zero, dl_zero;

  assign both_zero = ul_zero && dl_zero;
  assign idle      = !locked && !ul_valid && !dl_valid;

  always_comb begin
    if (ul_valid && dl_valid) pick_sel = contend_pick(ul_eff != '0, dl_eff != '0, last_served);
    else if (dl_valid)        pick_sel = CLS_DL;
    else                      pick_sel = CLS_UL;
  end

  assign cur_sel   = locked ? owner : pick_sel;
  assign grant_ok  = locked || ul_valid || dl_valid;
  assign out_valid = grant_ok && ((cur_sel == CLS_DL) ? dl_valid : ul_valid);
  assign out_last  = (cur_sel == CLS_DL) ? dl_last : ul_last;
  assign out_data  = (cur_sel == CLS_DL) ? dl_data : ul_data;
  assign out_class = (cur_sel == CLS_DL);
  assign ul_ready  = out_ready && grant_ok && (cur_sel == CLS_UL);
  assign dl_ready  = out_ready && grant_ok && (cur_sel == CLS_DL);
  assign fire      = out_valid && out_ready;
  assign fire_last = fire && out_last;

  cb_lock u_lock (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_last(fire_last),
    .pick_sel(pick_sel), .locked(locked), .owner(owner),
    .last_served(last_served), .start(start)
  );

  cb_credit #(.WW(WW), .UNIT(UNIT)) u_cred_ul (
    .clk(clk), .rst_n(rst_n), .weight(ul_weight), .round_reload(both_zero),
    .commit(start), .take(start && cur_sel == CLS_UL), .idle_reload(idle),
    .eff(ul_eff), .cnt_zero(ul_zero)
  );

  cb_credit #(.WW(WW), .UNIT(UNIT)) u_cred_dl (
    .clk(clk), .rst_n(rst_n), .weight(dl_weight), .round_reload(both_zero),
    .commit(start), .take(start && cur_sel == CLS_DL), .idle_reload(idle),
    .eff(dl_eff), .cnt_zero(dl_zero)
  );

  // R10: never two readies
  p_excl_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ul_ready, dl_ready}));
  // R3: no crossing while a block is in progress
  p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && owner == CLS_UL) |-> !dl_ready);
  p_no_cross_dl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && owner == CLS_DL) |-> !ul_ready);
  // R2: a lone waiting class goes through at once
  p_lone_ul_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && ul_valid && !dl_valid) |-> (out_valid && !out_class));
  p_lone_dl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && dl_valid && !ul_valid) |-> (out_valid && out_class));
  // R6: allowance beats no allowance
  p_credit_pref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && ul_valid && dl_valid && ul_eff != '0 && dl_eff == '0) |-> !out_class);
endmodule

// File: tb/cb_sched_top_tb_top.sv
module cb_sched_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  w_ul = 8'd1, w_dl = 8'd1;
  logic        ul_valid = 0, ul_last = 0, dl_valid = 0, dl_last = 0, out_ready = 0;
  logic [15:0] ul_data = '0, dl_data = '0;
  logic        ul_ready, dl_ready, out_valid, out_last, out_class;
  logic [15:0] out_data;

  int errors = 0, checks = 0;
  int m_cred[2], m_owner, m_last;
  bit m_lock;
  bit s_v[2];
  int s_rem[2], s_cnt[2];
  int seq[$];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cb_sched_top dut_i (
    .clk(clk), .rst_n(rst_n), .ul_weight(w_ul), .dl_weight(w_dl),
    .ul_valid(ul_valid), .ul_last(ul_last), .ul_data(ul_data), .ul_ready(ul_ready),
    .dl_valid(dl_valid), .dl_last(dl_last), .dl_data(dl_data), .dl_ready(dl_ready),
    .out_valid(out_valid), .out_last(out_last), .out_data(out_data),
    .out_class(out_class), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int allowance(input int c);
    return (c == 0) ? int'(w_ul) * 3 : int'(w_dl) * 3;
  endfunction

  function automatic logic [15:0] src_data(input int c);
    return {c[0], s_cnt[c][14:0]};
  endfunction

  task automatic do_reset();
    rst_n = 0; ul_valid = 0; dl_valid = 0; out_ready = 1;
    for (int c = 0; c < 2; c++) begin
      m_cred[c] = 0; s_v[c] = 0; s_rem[c] = 0; s_cnt[c] = 0;
    end
    m_lock = 0; m_owner = 0; m_last = 1;
    seq.delete();
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(!out_valid && !ul_ready && !dl_ready, "R1", "idle outputs after reset",
        {out_valid, ul_ready, dl_ready}, 0);
  endtask

  task automatic step(input int p_su, input int p_sd, input int p_val, input int p_rdy, input int maxlen);
    int e[2];
    int sel;
    string tag;
    bit ev, fire;
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      if (s_rem[c] == 0 && $urandom_range(99) < ((c == 0) ? p_su : p_sd))
        s_rem[c] = $urandom_range(maxlen, 1);
      if (s_rem[c] > 0 && !s_v[c]) s_v[c] = ($urandom_range(99) < p_val);
    end
    ul_valid = s_v[0]; ul_last = (s_rem[0] == 1); ul_data = src_data(0);
    dl_valid = s_v[1]; dl_last = (s_rem[1] == 1); dl_data = src_data(1);
    out_ready = ($urandom_range(99) < p_rdy);
    #1;
    for (int c = 0; c < 2; c++)
      e[c] = (m_cred[0] == 0 && m_cred[1] == 0) ? allowance(c) : m_cred[c];
    sel = -1; tag = "R2";
    if (m_lock) begin sel = m_owner; tag = "R3"; end
    else if (s_v[0] && s_v[1]) begin
      if ((e[0] > 0) == (e[1] > 0)) begin sel = 1 - m_last; tag = "R5"; end
      else begin sel = (e[0] > 0) ? 0 : 1; tag = "R6"; end
    end else if (s_v[0]) sel = 0;
    else if (s_v[1]) sel = 1;
    ev = (sel >= 0) && s_v[sel];
    chk(out_valid == ev, tag, "out_valid", out_valid, ev);
    if (ev) begin
      chk(out_class == sel[0], tag, "out_class", out_class, sel);
      chk(out_data == src_data(sel), "R9", "out_data", out_data, src_data(sel));
      chk(out_last == (s_rem[sel] == 1), "R9", "out_last", out_last, s_rem[sel] == 1);
    end
    chk(ul_ready == (out_ready && sel == 0), "R10", "ul_ready", ul_ready, out_ready && sel == 0);
    chk(dl_ready == (out_ready && sel == 1), "R10", "dl_ready", dl_ready, out_ready && sel == 1);
    fire = ev && out_ready;
    if (!m_lock && !s_v[0] && !s_v[1]) begin
      m_cred[0] = allowance(0); m_cred[1] = allowance(1);
    end
    if (fire) begin
      if (!m_lock) begin
        m_cred[sel] = (e[sel] > 0) ? e[sel] - 1 : 0;
        m_cred[1-sel] = e[1-sel];
        m_last = sel; m_owner = sel;
        m_lock = (s_rem[sel] != 1);
        seq.push_back(sel);
      end else if (s_rem[sel] == 1) m_lock = 0;
      s_cnt[sel]++; s_rem[sel]--; s_v[sel] = 0;
    end
  endtask

  task automatic run_blocks(input int n, input int p_su, input int p_sd);
    for (int g = 0; g < 2000 && seq.size() < n; g++) step(p_su, p_sd, 100, 100, 1);
  endtask

  initial begin
    int n_ul;
    bit ok;
    void'($urandom(32'h5EED_0C0B));
    out_ready = 1;

    // R4 and R5: 12:1 weights give 36:3 per round, first two alternate
    w_ul = 8'd12; w_dl = 8'd1; do_reset();
    run_blocks(39, 100, 100);
    n_ul = 0;
    for (int i = 0; i < 39 && i < seq.size(); i++) if (seq[i] == 0) n_ul++;
    chk(seq.size() >= 39 && n_ul == 36, "R4", "uplink blocks of 39", n_ul, 36);
    chk(seq.size() >= 2 && seq[0] == 0 && seq[1] == 1, "R5", "tie order", seq.size() >= 2 ? seq[0]*2+seq[1] : -1, 1);

    // R6 and R7: weights 2,1 -> U D U D U D U U U then reload -> D
    w_ul = 8'd2; w_dl = 8'd1; do_reset();
    run_blocks(10, 100, 100);
    chk(seq.size() >= 10 && seq[6] == 0 && seq[7] == 0 && seq[8] == 0, "R6", "credit holder wins",
        seq.size() >= 9 ? seq[6]+seq[7]+seq[8] : -1, 0);
    chk(seq.size() >= 10 && seq[9] == 1, "R7", "class after both exhausted", seq.size() >= 10 ? seq[9] : -1, 1);

    // R8: zero weight starves under contention
    w_ul = 8'd0; w_dl = 8'd2; do_reset();
    run_blocks(30, 100, 100);
    n_ul = 0;
    foreach (seq[i]) if (seq[i] == 0) n_ul++;
    chk(n_ul == 0, "R8", "zero-weight grants under contention", n_ul, 0);
    // R2: DL goes quiet, zero-weight UL served at once
    seq.delete();
    for (int i = 0; i < 6; i++) step(100, 0, 100, 100, 1);
    chk(seq.size() > 0 && seq[seq.size()-1] == 0, "R2", "lone zero-weight class served",
        seq.size() > 0 ? seq[seq.size()-1] : -1, 0);

    // R8: both weights zero alternate
    w_ul = 8'd0; w_dl = 8'd0; do_reset();
    run_blocks(12, 100, 100);
    ok = (seq.size() >= 12);
    for (int i = 1; i < seq.size(); i++) if (seq[i] == seq[i-1]) ok = 0;
    chk(ok, "R8", "round-robin alternation", ok, 1);

    // R7: idle gap reloads allowance (model tracks), then random traffic
    w_ul = 8'd1; w_dl = 8'd1; do_reset();
    run_blocks(2, 100, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 100, 100, 1);
    seq.delete();
    run_blocks(3, 100, 100);
    chk(seq.size() >= 3 && seq[0] == 1, "R7", "first after idle reload", seq.size() > 0 ? seq[0] : -1, 1);

    // R3 and R9: random weights, block lengths, gaps and back-pressure
    for (int r = 0; r < 6; r++) begin
      w_ul = 8'($urandom_range(5)); w_dl = 8'($urandom_range(5)); do_reset();
      for (int i = 0; i < 2500; i++) step(60 + r*6, 50 + r*8, 70, 75, 5);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule